// File: doc/BRIEF.md
# Clock Ratio Switch Sequencer

This block changes the CPU/DDR clock ratio without corrupting memory contents. Software presents a requested CPU frequency and DDR frequency in MHz together with a one-cycle start pulse. The block matches the pair against a fixed table of five supported settings. An unsupported pair is refused and nothing is touched. A supported pair starts a fixed walk: the DDR controller is asked to enter self-refresh, the block waits for its acknowledge, and an update strobe then moves the new ratio code into the ratio register. The block waits until the code can be read back, then waits for two DLL lock flags. It writes a rescaled refresh interval, releases self-refresh and pulses the self-refresh-exit request.

The ratio register has two copies. The master copy is written by the sequencer. The shadow copy is what readers see and what drives the decoded CPU frequency. The shadow takes the master value only on the update strobe. After reset the block takes the boot ratio code and the boot refresh interval, and from them works out a base refresh figure normalised to a 1 GHz DDR clock. Every later switch scales that figure to the new DDR clock. All divisions are done by one shared bit-serial divider. Each wait on the DDR side has a programmable timeout.

Top module: `clk_ratio_seq`

## Requirements
- R1: Supported (CPU MHz, DDR MHz) pairs map to ratio codes as 125/125→0x80, 333/167→0x32, 393/196→0x22, 500/200→0x13 and 500/250→0x12. When a switch to a supported pair completes, `rd_ratio_o` holds that pair's code.
- R2: A pair that is not in the table sets `err_inval_o`. It raises no self-refresh request and leaves `rd_ratio_o` unchanged.
- R3: `rd_ratio_o` (the shadow copy) changes only in the cycle after `upd_strobe_o`, or when the boot code is loaded after reset.
- R4: `sr_req_o` is raised before the update. `upd_strobe_o` is issued only after `sr_ack_i` has been seen high, and only while `sr_req_o` is high.
- R5: After the strobe, the block waits until the shadow equals the new code. It then waits until both `dll_lock_a_i` and `dll_lock_b_i` are high before it writes the refresh interval.
- R6: The new refresh interval is floor(base × new DDR MHz / 1000), capped at 16383. `refresh_wr_o` pulses with `refresh_val_o` only when this value is nonzero. The write waits for the divider result.
- R7: After reset, base = floor(boot_refresh × 1000 / DDR MHz of the boot code). A boot code outside the table is treated as 250 MHz DDR.
- R8: To finish, `sr_req_o` is cleared first. Then `sr_exit_o` pulses for one cycle while `sr_req_o` is low, followed by a one-cycle `done_o`.
- R9: `cpu_khz_o` decodes shadow bits [7:4] as follows: 0→600000, 1→500000, 2→393000, 3→333000, 4/5/8/9→125000, 6→196608, 7→166000. Any other value gives 393000.
- R10: `busy_o` is high from the cycle after an accepted start until the block is back in idle. A start while busy has no effect on the switch in flight and sets the sticky `req_dropped_o`.
- R11: A wait on acknowledge, shadow match or DLL lock that stays unmet for `tmo_limit_i`+1 cycles sets `err_timeout_o`, clears `sr_req_o` and returns the block to idle. The next accepted start clears `err_timeout_o`, `err_inval_o` and `req_dropped_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to switch |
| req_cpu_mhz_i | input | 10 | Requested CPU frequency in MHz |
| req_ddr_mhz_i | input | 10 | Requested DDR frequency in MHz |
| boot_code_i | input | 8 | Ratio code in force at power-up, loaded after reset |
| boot_refresh_i | input | 14 | Refresh interval in force at power-up |
| tmo_limit_i | input | 16 | Timeout limit for each wait state, in cycles |
| sr_ack_i | input | 1 | Self-refresh acknowledge from the DDR controller |
| dll_lock_a_i | input | 1 | First DLL lock flag |
| dll_lock_b_i | input | 1 | Second DLL lock flag |
| rd_ratio_o | output | 8 | Shadow ratio code (the readable copy) |
| cpu_khz_o | output | 20 | CPU frequency in kHz decoded from the shadow |
| sr_req_o | output | 1 | Self-refresh request level |
| upd_strobe_o | output | 1 | Update strobe, moves master into shadow |
| refresh_wr_o | output | 1 | Write pulse for the refresh interval |
| refresh_val_o | output | 14 | New refresh interval |
| sr_exit_o | output | 1 | Power-up self-refresh exit pulse |
| busy_o | output | 1 | Sequencer is not idle |
| done_o | output | 1 | One-cycle completion pulse |
| err_inval_o | output | 1 | Sticky: unsupported pair requested |
| err_timeout_o | output | 1 | Sticky: a wait timed out |
| req_dropped_o | output | 1 | Sticky: a start arrived while busy |

## Verification
The bench targets these corner cases, and says what a faulty design would do in each:
- An unsupported pair. A faulty design would start a self-refresh handshake or rewrite the shadow.
- A second start in mid-sequence. A faulty design would retarget the switch instead of only raising the dropped flag.
- An acknowledge that never comes. A faulty design would hang, or keep DDR in self-refresh for a number of cycles other than the limit plus one.
- A DLL lock that never comes after the shadow has already moved. The same faults as the previous case apply.
- Three boot cases: an unknown code (a wrong fallback gives a wrong refresh value), a large interval (a missing cap wraps the 14-bit field), and a zero interval (a missing nonzero guard writes 0).

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int CODE_W = 8;
  localparam int MHZ_W  = 10;
  localparam int KHZ_W  = 20;

  typedef enum logic [3:0] {
    S_INIT, S_INIT_DIV, S_IDLE, S_CHECK, S_SR_REQ, S_SR_WAIT,
    S_UPDATE, S_SHADOW_WAIT, S_DLL_WAIT, S_REFRESH_WR, S_SR_EXIT, S_DONE
  } seq_state_e;

  // returns {supported, code}
  function automatic logic [CODE_W:0] pair_code(input logic [MHZ_W-1:0] cpu,
                                                input logic [MHZ_W-1:0] ddr);
    case ({cpu, ddr})
      {10'd125, 10'd125}: return {1'b1, 8'h80};
      {10'd333, 10'd167}: return {1'b1, 8'h32};
      {10'd393, 10'd196}: return {1'b1, 8'h22};
      {10'd500, 10'd200}: return {1'b1, 8'h13};
      {10'd500, 10'd250}: return {1'b1, 8'h12};
      default:            return '0;
    endcase
  endfunction

  // DDR MHz implied by a code; unknown codes fall back to 250
  function automatic logic [MHZ_W-1:0] ddr_of_code(input logic [CODE_W-1:0] code);
    case (code)
      8'h80:   return 10'd125;
      8'h32:   return 10'd167;
      8'h22:   return 10'd196;
      8'h13:   return 10'd200;
      default: return 10'd250;
    endcase
  endfunction

  function automatic logic [KHZ_W-1:0] cpu_khz_of(input logic [3:0] sel);
    case (sel)
      4'd0:                    return 20'd600000;
      4'd1:                    return 20'd500000;
      4'd2:                    return 20'd393000;
      4'd3:                    return 20'd333000;
      4'd4, 4'd5, 4'd8, 4'd9:  return 20'd125000;
      4'd6:                    return 20'd196608;
      4'd7:                    return 20'd166000;
      default:                 return 20'd393000;
    endcase
  endfunction
endpackage

// File: rtl/crs_seq_div.sv
module crs_seq_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, valid_q;
  logic [W:0]    rem_sh, diff;

  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; valid_q <= 1'b0;
    end else if (start_i) begin
      rem_q <= '0; quo_q <= dividend_i; dvs_q <= divisor_i;
      cnt_q <= CW'(W); run_q <= 1'b1; valid_q <= 1'b0;
    end else if (run_q) begin
      if (!diff[W]) begin
        rem_q <= diff[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  assign quotient_o = quo_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/crs_wait_timer.sv
module crs_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
  import crs_pkg::*;
#(
  parameter int               REF_W      = 14,
  parameter int               TMO_W      = 16,
  parameter int               DIV_W      = 32,
  parameter logic [7:0]       RESET_CODE = 8'h12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [9:0]         req_cpu_mhz_i,
  input  logic [9:0]         req_ddr_mhz_i,
  input  logic [7:0]         boot_code_i,
  input  logic [REF_W-1:0]   boot_refresh_i,
  input  logic [TMO_W-1:0]   tmo_limit_i,
  input  logic               sr_ack_i,
  input  logic               dll_lock_a_i,
  input  logic               dll_lock_b_i,
  output logic [7:0]         rd_ratio_o,
  output logic [19:0]        cpu_khz_o,
  output logic               sr_req_o,
  output logic               upd_strobe_o,
  output logic               refresh_wr_o,
  output logic [REF_W-1:0]   refresh_val_o,
  output logic               sr_exit_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_inval_o,
  output logic               err_timeout_o,
  output logic               req_dropped_o
);
  localparam logic [DIV_W-1:0] REF_MAX = DIV_W'((1 << REF_W) - 1);
  localparam logic [DIV_W-1:0] KILO    = DIV_W'(1000);

  seq_state_e          st_q, st_d;
  logic [CODE_W-1:0]   master_q, shadow_q, pair_code_w;
  logic [MHZ_W-1:0]    req_cpu_q, req_ddr_q;
  logic [DIV_W-1:0]    base_q, div_a, div_b, div_quo_w;
  logic                sr_req_q, err_inval_q, err_tmo_q, dropped_q;
  logic                pair_ok_w, div_start, div_valid_w, wait_cond, in_wait;
  logic                tmo_expired_w;

  // named internal events
  logic accept_w, drop_w, init_load_w, upd_strobe_w, tmo_hit_w, leave_sr_w;

  assign {pair_ok_w, pair_code_w} = pair_code(req_cpu_q, req_ddr_q);
  assign accept_w     = start_i && (st_q == S_IDLE);
  assign drop_w       = start_i && (st_q != S_IDLE);
  assign init_load_w  = (st_q == S_INIT);
  assign upd_strobe_w = (st_q == S_UPDATE);
  assign in_wait      = (st_q == S_SR_WAIT) || (st_q == S_SHADOW_WAIT) || (st_q == S_DLL_WAIT);
  assign tmo_hit_w    = in_wait && !wait_cond && tmo_expired_w;
  assign leave_sr_w   = (st_q == S_REFRESH_WR) && div_valid_w;

  always_comb begin
    st_d      = st_q;
    div_start = 1'b0;
    div_a     = '0;
    div_b     = '0;
    wait_cond = 1'b0;
    case (st_q)
      S_INIT: begin
        div_start = 1'b1;
        div_a     = DIV_W'(boot_refresh_i) * KILO;
        div_b     = DIV_W'(ddr_of_code(boot_code_i));
        st_d      = S_INIT_DIV;
      end
      S_INIT_DIV:    if (div_valid_w) st_d = S_IDLE;
      S_IDLE:        if (start_i) st_d = S_CHECK;
      S_CHECK: begin
        if (pair_ok_w) begin
          div_start = 1'b1;
          div_a     = base_q * DIV_W'(req_ddr_q);
          div_b     = KILO;
          st_d      = S_SR_REQ;
        end else begin
          st_d = S_IDLE;
        end
      end
      S_SR_REQ:      st_d = S_SR_WAIT;
      S_SR_WAIT: begin
        wait_cond = sr_ack_i;
        if (wait_cond) st_d = S_UPDATE;
        else if (tmo_expired_w) st_d = S_IDLE;
      end
      S_UPDATE:      st_d = S_SHADOW_WAIT;
      S_SHADOW_WAIT: begin
        wait_cond = (shadow_q == master_q);
        if (wait_cond) st_d = S_DLL_WAIT;
        else if (tmo_expired_w) st_d = S_IDLE;
      end
      S_DLL_WAIT: begin
        wait_cond = dll_lock_a_i && dll_lock_b_i;
        if (wait_cond) st_d = S_REFRESH_WR;
        else if (tmo_expired_w) st_d = S_IDLE;
      end
      S_REFRESH_WR:  if (div_valid_w) st_d = S_SR_EXIT;
      S_SR_EXIT:     st_d = S_DONE;
      S_DONE:        st_d = S_IDLE;
      default:       st_d = S_IDLE;
    endcase
  end

  crs_seq_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start),
    .dividend_i(div_a), .divisor_i(div_b),
    .quotient_o(div_quo_w), .valid_o(div_valid_w)
  );

  crs_wait_timer #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr_i(!in_wait || (st_d != st_q)),
    .limit_i(tmo_limit_i), .expired_o(tmo_expired_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_INIT;
      master_q    <= RESET_CODE;
      shadow_q    <= RESET_CODE;
      req_cpu_q   <= '0;
      req_ddr_q   <= '0;
      base_q      <= '0;
      sr_req_q    <= 1'b0;
      err_inval_q <= 1'b0;
      err_tmo_q   <= 1'b0;
      dropped_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (init_load_w) begin
        master_q <= boot_code_i;
        shadow_q <= boot_code_i;
      end
      if ((st_q == S_INIT_DIV) && div_valid_w) base_q <= div_quo_w;
      if (accept_w) begin
        req_cpu_q   <= req_cpu_mhz_i;
        req_ddr_q   <= req_ddr_mhz_i;
        err_inval_q <= 1'b0;
        err_tmo_q   <= 1'b0;
        dropped_q   <= 1'b0;
      end
      if (drop_w) dropped_q <= 1'b1;
      if (st_q == S_CHECK) begin
        if (pair_ok_w) master_q <= pair_code_w;
        else           err_inval_q <= 1'b1;
      end
      if (upd_strobe_w)          shadow_q <= master_q;
      if (st_q == S_SR_REQ)      sr_req_q <= 1'b1;
      if (leave_sr_w || tmo_hit_w) sr_req_q <= 1'b0;
      if (tmo_hit_w)             err_tmo_q <= 1'b1;
    end
  end

  assign rd_ratio_o    = shadow_q;
  assign cpu_khz_o     = cpu_khz_of(shadow_q[7:4]);
  assign sr_req_o      = sr_req_q;
  assign upd_strobe_o  = upd_strobe_w;
  assign refresh_wr_o  = leave_sr_w && (div_quo_w != '0);
  assign refresh_val_o = (div_quo_w > REF_MAX) ? REF_MAX[REF_W-1:0] : div_quo_w[REF_W-1:0];
  assign sr_exit_o     = (st_q == S_SR_EXIT);
  assign busy_o        = (st_q != S_IDLE);
  assign done_o        = (st_q == S_DONE);
  assign err_inval_o   = err_inval_q;
  assign err_timeout_o = err_tmo_q;
  assign req_dropped_o = dropped_q;
endmodule

// File: rtl/crs_checker.sv
module crs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       sr_req_o,
  input logic       upd_strobe_o,
  input logic [7:0] rd_ratio_o,
  input logic       init_load_w,
  input logic       sr_exit_o,
  input logic       refresh_wr_o,
  input logic       done_o,
  input logic       err_inval_o,
  input logic       req_dropped_o,
  input logic       dll_lock_a_i,
  input logic       dll_lock_b_i,
  input logic       tmo_hit_w
);
  p_upd_in_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe_o |-> sr_req_o);

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_strobe_o && !init_load_w) |=> $stable(rd_ratio_o));

  p_refresh_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_wr_o |-> (sr_req_o && dll_lock_a_i && dll_lock_b_i));

  p_exit_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_o |-> !sr_req_o);

  p_exit_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_o |=> done_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_inval_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_inval_o) |-> !sr_req_o);

  p_drop_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> req_dropped_o);

  p_tmo_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit_w |=> (!sr_req_o && !busy_o));
endmodule

bind clk_ratio_seq crs_checker u_crs_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .sr_req_o(sr_req_o), .upd_strobe_o(upd_strobe_o), .rd_ratio_o(rd_ratio_o),
  .init_load_w(init_load_w), .sr_exit_o(sr_exit_o), .refresh_wr_o(refresh_wr_o),
  .done_o(done_o), .err_inval_o(err_inval_o), .req_dropped_o(req_dropped_o),
  .dll_lock_a_i(dll_lock_a_i), .dll_lock_b_i(dll_lock_b_i), .tmo_hit_w(tmo_hit_w)
);

// File: tb/clk_ratio_seq_tb_top.sv
module clk_ratio_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [9:0]  req_cpu = '0, req_ddr = '0;
  logic [7:0]  boot_code = 8'h13;
  logic [13:0] boot_refresh = '0;
  logic [15:0] tmo_limit = 16'(TMO);
  logic        sr_ack = 1'b0, lock_a = 1'b1, lock_b = 1'b1;
  logic [7:0]  rd_ratio;
  logic [19:0] cpu_khz;
  logic        sr_req, upd_strobe, refresh_wr, sr_exit, busy, done;
  logic        err_inval, err_timeout, req_dropped;
  logic [13:0] refresh_val;

  clk_ratio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .req_cpu_mhz_i(req_cpu),
    .req_ddr_mhz_i(req_ddr), .boot_code_i(boot_code), .boot_refresh_i(boot_refresh),
    .tmo_limit_i(tmo_limit), .sr_ack_i(sr_ack), .dll_lock_a_i(lock_a),
    .dll_lock_b_i(lock_b), .rd_ratio_o(rd_ratio), .cpu_khz_o(cpu_khz),
    .sr_req_o(sr_req), .upd_strobe_o(upd_strobe), .refresh_wr_o(refresh_wr),
    .refresh_val_o(refresh_val), .sr_exit_o(sr_exit), .busy_o(busy), .done_o(done),
    .err_inval_o(err_inval), .err_timeout_o(err_timeout), .req_dropped_o(req_dropped)
  );

  int checks = 0, failures = 0;
  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: CPU kHz from the upper nibble (R9)
  function automatic int khz_ref(input logic [7:0] c);
    int s;
    s = int'(c) / 16;
    if (s == 4 || s == 5 || s == 8 || s == 9) return 125000;
    if (s == 0) return 600000;
    if (s == 1) return 500000;
    if (s == 3) return 333000;
    if (s == 6) return 196608;
    if (s == 7) return 166000;
    return 393000;
  endfunction

  function automatic int ddr_ref(input logic [7:0] c);
    if (c == 8'h80) return 125;
    if (c == 8'h32) return 167;
    if (c == 8'h22) return 196;
    if (c == 8'h13) return 200;
    return 250;
  endfunction

  // model state
  bit          model_on = 0, ack_en = 1, lock_en = 1;
  logic [7:0]  exp_shadow = '0, exp_target = '0;
  bit          wr_seen, done_seen, exit_seen, strobe_seen;
  int          wr_val, sr_run = 0, sr_last = 0, lock_cnt = 100, base_ref = 0;
  logic [2:0]  ack_pipe = '0;

  // per-clock reference comparison and DDR/DLL environment model
  always @(negedge clk) begin
    if (model_on) begin
      check("R3 shadow copy", rd_ratio == exp_shadow, rd_ratio, exp_shadow);
      check("R9 cpu khz", int'(cpu_khz) == khz_ref(exp_shadow), cpu_khz, khz_ref(exp_shadow));
      if (sr_exit && sr_req) check("R8 exit while sr_req", 0, 1, 0);
      if (refresh_wr) begin wr_seen = 1; wr_val = int'(refresh_val); end
      if (done) done_seen = 1;
      if (sr_exit) exit_seen = 1;
      if (upd_strobe) begin exp_shadow = exp_target; strobe_seen = 1; end
    end
    if (sr_req) sr_run++;
    else if (sr_run != 0) begin sr_last = sr_run; sr_run = 0; end
    if (!rst_n) ack_pipe = '0;
    else ack_pipe = {ack_pipe[1:0], sr_req & ack_en};
    sr_ack = ack_pipe[2];
    if (upd_strobe) lock_cnt = 0;
    else if (lock_cnt < 100) lock_cnt++;
    lock_a = lock_en && (lock_cnt >= 4);
    lock_b = lock_en && (lock_cnt >= 7);
  end

  task automatic do_reset(input logic [7:0] code, input int refr);
    model_on = 0;
    rst_n = 0; boot_code = code; boot_refresh = 14'(refr);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    base_ref = refr * 1000 / ddr_ref(code);
    exp_shadow = code;
    model_on = 1;
    check("R7 reset idle", !busy && !sr_req && !err_inval && !err_timeout && !req_dropped, busy, 0);
    check("R7 boot code loaded", rd_ratio == code, rd_ratio, code);
  endtask

  task automatic do_switch(input int cpu, input int ddr, input logic [7:0] code, input bit extra);
    exp_target = code; wr_seen = 0; done_seen = 0; exit_seen = 0; strobe_seen = 0; sr_last = 0;
    @(negedge clk); start = 1; req_cpu = 10'(cpu); req_ddr = 10'(ddr);
    @(negedge clk); start = 0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start = 1; req_cpu = 10'd600; req_ddr = 10'd300;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int refresh_ref(input int ddr);
    int v;
    v = base_ref * ddr / 1000;
    return (v > 16383) ? 16383 : v;
  endfunction

  task automatic good_switch(input int cpu, input int ddr, input logic [7:0] code, input string tag);
    int exp;
    exp = refresh_ref(ddr);
    do_switch(cpu, ddr, code, 0);
    check({tag, " R1 code"}, rd_ratio == code, rd_ratio, code);
    check({tag, " R6 refresh"}, wr_seen && wr_val == exp, wr_val, exp);
    check({tag, " R8 exit and done"}, exit_seen && done_seen && !sr_req, {exit_seen, done_seen}, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // boot at 500/200, base = 1560*1000/200 = 7800 (R7)
    do_reset(8'h13, 1560);
    check("R9 boot 500MHz", cpu_khz == 20'd500000, cpu_khz, 500000);
    good_switch(125, 125, 8'h80, "S1");   // 975
    good_switch(333, 167, 8'h32, "S2");   // 1302
    good_switch(393, 196, 8'h22, "S3");   // 1528
    check("R4 strobe seen", strobe_seen, strobe_seen, 1);

    // R2: unsupported pair
    do_switch(600, 300, 8'h22, 0);
    check("R2 inval flag", err_inval, err_inval, 1);
    check("R2 no handshake", sr_last == 0 && !strobe_seen, sr_last, 0);
    check("R2 shadow kept", rd_ratio == 8'h22, rd_ratio, 8'h22);

    // R10: second start while busy is dropped
    do_switch(500, 250, 8'h12, 1);
    check("R10 dropped sticky", req_dropped, req_dropped, 1);
    check("R10 first target kept", rd_ratio == 8'h12 && !err_inval, rd_ratio, 8'h12);
    check("R6 refresh 500/250", wr_seen && wr_val == refresh_ref(250), wr_val, refresh_ref(250));

    // R11: acknowledge never arrives
    ack_en = 0;
    do_switch(500, 200, 8'h13, 0);
    ack_en = 1;
    check("R11 ack timeout flag", err_timeout && !sr_req && !busy, err_timeout, 1);
    check("R11 sr window", sr_last == TMO + 1, sr_last, TMO + 1);
    check("R11 no strobe on ack timeout", !strobe_seen && rd_ratio == 8'h12, rd_ratio, 8'h12);
    check("R10 dropped cleared", !req_dropped, req_dropped, 0);

    // R5/R11: DLL never relocks
    lock_en = 0;
    do_switch(500, 200, 8'h13, 0);
    lock_en = 1;
    check("R5 no refresh without lock", !wr_seen && !done_seen, wr_seen, 0);
    check("R11 lock timeout", err_timeout && !sr_req && rd_ratio == 8'h13, err_timeout, 1);

    good_switch(125, 125, 8'h80, "S8");
    check("R11 flags cleared", !err_timeout && !req_dropped && !err_inval, err_timeout, 0);

    // R7: unknown boot code -> 250 MHz assumed, base 4000; R9 default decode
    do_reset(8'hF0, 1000);
    check("R9 default decode", cpu_khz == 20'd393000, cpu_khz, 393000);
    good_switch(500, 200, 8'h13, "S9");   // 800

    // R6: cap at 16383
    do_reset(8'h80, 16383);
    check("R9 boot 125MHz", cpu_khz == 20'd125000, cpu_khz, 125000);
    good_switch(500, 250, 8'h12, "S10");

    // R6: zero result is not written
    do_reset(8'h32, 0);
    do_switch(125, 125, 8'h80, 0);
    check("R6 zero not written", !wr_seen && done_seen && rd_ratio == 8'h80, wr_seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule